// File: doc/BRIEF.md
# Converter Fault Supervisor

This block sits beside the start-up and regulation sequencer of a digitally controlled step-down converter and decides when the power stage must be shut down. On every sample strobe it reads the input-voltage code, the output-voltage code and the reference code that the regulation loop is currently tracking. It then judges three conditions: input below an undervoltage limit, input above an overvoltage limit, and output away from the live reference by more than a tolerance band. The reference may still be ramping, so the output is always compared with that moving value and never with a fixed target.

Each condition has its own fault flag. A flag sets only after its condition has lasted for a configured number of millisecond ticks. It clears only after the condition has been absent for a configured recovery time, so the sequencer restarts the converter without outside help. While any flag is set, the block holds a registered shutdown request. It also reports a two-bit cause code naming the fault that started the shutdown. The regulation check is gated off by the sequencer until the converter is ramping or regulating. The input window check runs at all times.

Top module: `conv_fault_supervisor`

## Requirements
- R1: After a synchronous reset `shutdown_req` is 0 and `fault_cause` is 2'b00 (none).
- R2: An input code strictly below `uv_level` that persists for `in_trip_ms` ticks of `ms_tick` raises `shutdown_req` with `fault_cause` 2'b01.
- R3: An input code strictly above `ov_level` that persists for `in_trip_ms` ticks raises `shutdown_req` with `fault_cause` 2'b10.
- R4: When the absolute difference between `vout_code` and the current `vref_code` exceeds `reg_tol` for `reg_trip_ms` ticks, `shutdown_req` rises with `fault_cause` 2'b11.
- R5: Any sample whose condition is absent resets that check's trip count to zero, so persistence must start again.
- R6: After a condition clears, its fault is released only after `recov_ms` ticks with the condition absent; if the condition reappears during that time, the recovery count restarts from zero. `shutdown_req` falls and `fault_cause` returns to 2'b00 once no fault remains.
- R7: While `reg_check_en` is 0, regulation error never trips. The input window checks stay active regardless of `reg_check_en`.
- R8: `fault_cause` keeps the code of the first fault for as long as `shutdown_req` stays high. Faults that trip in the same cycle rank undervoltage, then overvoltage, then regulation error.
- R9: Voltage and reference codes are taken only in cycles where `sample_vld` is 1. Changes between strobes have no effect.
- R10: Values exactly at `uv_level`, at `ov_level`, or with a difference equal to `reg_tol` are not faults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | Strobe marking a new set of codes |
| vin_code | input | CODE_W | Input-voltage sample code |
| vout_code | input | CODE_W | Output-voltage sample code |
| vref_code | input | CODE_W | Live regulation reference code |
| uv_level | input | CODE_W | Undervoltage limit code |
| ov_level | input | CODE_W | Overvoltage limit code |
| reg_tol | input | CODE_W | Allowed output deviation from reference |
| in_trip_ms | input | MS_W | Persistence for input window faults, in ticks |
| reg_trip_ms | input | MS_W | Persistence for regulation fault, in ticks |
| recov_ms | input | MS_W | Recovery delay for every fault, in ticks |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| reg_check_en | input | 1 | Sequencer is ramping or regulating |
| shutdown_req | output | 1 | Registered shutdown request |
| fault_cause | output | 2 | Cause of the present shutdown: 00 none, 01 undervoltage, 10 overvoltage, 11 regulation |

## Verification
The assertions assume that the limit and delay inputs stay constant while a fault is timing. They also assume that `ms_tick` is a single-cycle pulse and that `uv_level` is below `ov_level`, so both input faults can never be true together. The bench changes configuration only while every check is idle. It drives each tick and each strobe as a one-cycle pulse spaced several clocks apart. It keeps every input code on one side of a single limit at a time.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_UV   = 2'b01,
    CAUSE_OV   = 2'b10,
    CAUSE_REG  = 2'b11
  } cause_e;

  localparam int unsigned NUM_CHK = 3;
  localparam int unsigned CHK_UV  = 0;
  localparam int unsigned CHK_OV  = 1;
  localparam int unsigned CHK_REG = 2;
endpackage

// File: rtl/cfs_sample_eval.sv
module cfs_sample_eval #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_vld,
  input  logic [CODE_W-1:0] vin_code,
  input  logic [CODE_W-1:0] vout_code,
  input  logic [CODE_W-1:0] vref_code,
  input  logic [CODE_W-1:0] uv_level,
  input  logic [CODE_W-1:0] ov_level,
  input  logic [CODE_W-1:0] reg_tol,
  input  logic              reg_check_en,
  output logic [cfs_pkg::NUM_CHK-1:0] cond
);
  import cfs_pkg::*;

  logic [NUM_CHK-1:0] cond_q;
  logic [CODE_W-1:0]  dev;

  // magnitude of output deviation from the live reference
  always_comb begin
    if (vout_code >= vref_code) dev = vout_code - vref_code;
    else                        dev = vref_code - vout_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= '0;
    end else if (sample_vld) begin
      cond_q[CHK_UV]  <= (vin_code < uv_level);
      cond_q[CHK_OV]  <= (vin_code > ov_level);
      cond_q[CHK_REG] <= (dev > reg_tol);
    end
  end

  // regulation verdict is masked outside ramp/regulation
  assign cond = {cond_q[CHK_REG] & reg_check_en, cond_q[CHK_OV], cond_q[CHK_UV]};

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !sample_vld |=> $stable(cond_q)); // R9

  AST_MASKED_REG: assert property (@(posedge clk) disable iff (rst)
    !reg_check_en |-> !cond[CHK_REG]); // R7
endmodule

// File: rtl/cfs_fault_timer.sv
module cfs_fault_timer #(
  parameter int unsigned MS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cond,
  input  logic            ms_tick,
  input  logic [MS_W-1:0] trip_ms,
  input  logic [MS_W-1:0] recov_ms,
  output logic            flag
);
  localparam int unsigned EXT_W = MS_W + 1;

  logic [MS_W-1:0]  cnt_q;
  logic             flag_q;
  logic [EXT_W-1:0] cnt_nx;
  logic             trip_hit;
  logic             recov_hit;

  assign cnt_nx    = {1'b0, cnt_q} + EXT_W'(1);
  assign trip_hit  = (trip_ms == '0)  || (ms_tick && (cnt_nx >= {1'b0, trip_ms}));
  assign recov_hit = (recov_ms == '0) || (ms_tick && (cnt_nx >= {1'b0, recov_ms}));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!flag_q) begin
      if (!cond) begin
        cnt_q <= '0;
      end else if (trip_hit) begin
        flag_q <= 1'b1;
        cnt_q  <= '0;
      end else if (ms_tick) begin
        cnt_q <= cnt_nx[MS_W-1:0];
      end
    end else begin
      if (cond) begin
        cnt_q <= '0;
      end else if (recov_hit) begin
        flag_q <= 1'b0;
        cnt_q  <= '0;
      end else if (ms_tick) begin
        cnt_q <= cnt_nx[MS_W-1:0];
      end
    end
  end

  assign flag = flag_q;

  AST_TRIP_NEEDS_COND: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(cond)); // R2

  AST_RELEASE_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> !$past(cond)); // R6

  AST_TRIP_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !cond) |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/conv_fault_supervisor.sv
module conv_fault_supervisor #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned MS_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_vld,
  input  logic [CODE_W-1:0] vin_code,
  input  logic [CODE_W-1:0] vout_code,
  input  logic [CODE_W-1:0] vref_code,
  input  logic [CODE_W-1:0] uv_level,
  input  logic [CODE_W-1:0] ov_level,
  input  logic [CODE_W-1:0] reg_tol,
  input  logic [MS_W-1:0]   in_trip_ms,
  input  logic [MS_W-1:0]   reg_trip_ms,
  input  logic [MS_W-1:0]   recov_ms,
  input  logic              ms_tick,
  input  logic              reg_check_en,
  output logic              shutdown_req,
  output logic [1:0]        fault_cause
);
  import cfs_pkg::*;

  logic [NUM_CHK-1:0] cond;
  logic [NUM_CHK-1:0] flags;
  logic               sd_q;
  cause_e             cause_q;
  cause_e             first_c;

  cfs_sample_eval #(.CODE_W(CODE_W)) u_eval (
    .clk(clk), .rst(rst), .sample_vld(sample_vld),
    .vin_code(vin_code), .vout_code(vout_code), .vref_code(vref_code),
    .uv_level(uv_level), .ov_level(ov_level), .reg_tol(reg_tol),
    .reg_check_en(reg_check_en), .cond(cond)
  );

  for (genvar g = 0; g < NUM_CHK; g++) begin : g_chk
    localparam bit IS_REG = (g == CHK_REG);
    cfs_fault_timer #(.MS_W(MS_W)) u_tmr (
      .clk(clk), .rst(rst), .cond(cond[g]), .ms_tick(ms_tick),
      .trip_ms(IS_REG ? reg_trip_ms : in_trip_ms),
      .recov_ms(recov_ms), .flag(flags[g])
    );
  end

  // same-cycle ranking: undervoltage, overvoltage, regulation
  always_comb begin
    if      (flags[CHK_UV])  first_c = CAUSE_UV;
    else if (flags[CHK_OV])  first_c = CAUSE_OV;
    else if (flags[CHK_REG]) first_c = CAUSE_REG;
    else                     first_c = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_q    <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      sd_q <= |flags;
      if (flags == '0)              cause_q <= CAUSE_NONE;
      else if (cause_q == CAUSE_NONE) cause_q <= first_c;
    end
  end

  assign shutdown_req = sd_q;
  assign fault_cause  = cause_q;

  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (rst)
    (sd_q && $past(sd_q)) |-> $stable(cause_q)); // R8

  AST_IDLE_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !sd_q |-> (cause_q == CAUSE_NONE)); // R1

  AST_SD_FROM_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_q) |-> $past(flags != '0)); // R2
endmodule

// File: tb/conv_fault_supervisor_tb.sv
module conv_fault_supervisor_tb;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned MS_W   = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sample_vld = 1'b0;
  logic [CODE_W-1:0] vin_code = 12'd480;
  logic [CODE_W-1:0] vout_code = 12'd200;
  logic [CODE_W-1:0] vref_code = 12'd200;
  logic [CODE_W-1:0] uv_level = 12'd415;
  logic [CODE_W-1:0] ov_level = 12'd595;
  logic [CODE_W-1:0] reg_tol = 12'd5;
  logic [MS_W-1:0]   in_trip_ms = 8'd2;
  logic [MS_W-1:0]   reg_trip_ms = 8'd10;
  logic [MS_W-1:0]   recov_ms = 8'd4;
  logic              ms_tick = 1'b0;
  logic              reg_check_en = 1'b1;
  logic              shutdown_req;
  logic [1:0]        fault_cause;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  conv_fault_supervisor #(.CODE_W(CODE_W), .MS_W(MS_W)) u_dut (
    .clk(clk), .rst(rst), .sample_vld(sample_vld),
    .vin_code(vin_code), .vout_code(vout_code), .vref_code(vref_code),
    .uv_level(uv_level), .ov_level(ov_level), .reg_tol(reg_tol),
    .in_trip_ms(in_trip_ms), .reg_trip_ms(reg_trip_ms), .recov_ms(recov_ms),
    .ms_tick(ms_tick), .reg_check_en(reg_check_en),
    .shutdown_req(shutdown_req), .fault_cause(fault_cause)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sample(input int vi, input int vo, input int vr);
    @(negedge clk);
    vin_code = CODE_W'(vi); vout_code = CODE_W'(vo); vref_code = CODE_W'(vr);
    sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 shutdown after reset", int'(shutdown_req), 0);
    chk("R1 cause after reset", int'(fault_cause), 0);
  endtask

  task automatic t_uv_recover;
    sample(400, 200, 200);
    ticks(1);
    chk("R2 uv before persistence", int'(shutdown_req), 0);
    ticks(1);
    chk("R2 uv trips", int'(shutdown_req), 1);
    chk("R2 uv cause", int'(fault_cause), 1);
    sample(480, 200, 200);
    ticks(3);
    chk("R6 held during recovery", int'(shutdown_req), 1);
    sample(400, 200, 200);
    sample(480, 200, 200);
    ticks(3);
    chk("R6 recovery restarted", int'(shutdown_req), 1);
    ticks(1);
    chk("R6 released", int'(shutdown_req), 0);
    chk("R6 cause cleared", int'(fault_cause), 0);
  endtask

  task automatic t_ov_and_limits;
    sample(595, 200, 200);
    ticks(5);
    chk("R10 at ov limit", int'(shutdown_req), 0);
    sample(415, 200, 200);
    ticks(5);
    chk("R10 at uv limit", int'(shutdown_req), 0);
    sample(600, 200, 200);
    ticks(2);
    chk("R3 ov trips", int'(shutdown_req), 1);
    chk("R3 ov cause", int'(fault_cause), 2);
    sample(480, 200, 200);
    ticks(4);
    chk("R3 ov released", int'(shutdown_req), 0);
  endtask

  task automatic t_regulation;
    sample(480, 200, 195);
    ticks(12);
    chk("R10 deviation equal tol", int'(shutdown_req), 0);
    sample(480, 200, 210);
    ticks(5);
    sample(480, 206, 210);
    sample(480, 200, 210);
    ticks(9);
    chk("R5 trip count restarted", int'(shutdown_req), 0);
    ticks(1);
    chk("R4 reg trips", int'(shutdown_req), 1);
    chk("R4 reg cause", int'(fault_cause), 3);
    sample(480, 210, 210);
    ticks(4);
    chk("R4 reg released", int'(shutdown_req), 0);
    sample(480, 150, 140);
    ticks(10);
    chk("R4 moving ref trips", int'(fault_cause), 3);
    sample(480, 150, 152);
    ticks(4);
    chk("R4 tracks new ref", int'(shutdown_req), 0);
  endtask

  task automatic t_mask;
    @(negedge clk); reg_check_en = 1'b0;
    sample(480, 0, 200);
    ticks(12);
    chk("R7 reg masked", int'(shutdown_req), 0);
    sample(400, 0, 200);
    ticks(2);
    chk("R7 input check active", int'(fault_cause), 1);
    sample(480, 200, 200);
    ticks(4);
    chk("R7 released", int'(shutdown_req), 0);
    @(negedge clk); reg_check_en = 1'b1;
  endtask

  task automatic t_priority;
    sample(400, 200, 200);
    ticks(2);
    sample(400, 100, 200);
    ticks(10);
    chk("R8 first cause kept", int'(fault_cause), 1);
    sample(480, 100, 200);
    ticks(4);
    chk("R8 still shut by reg", int'(shutdown_req), 1);
    chk("R8 cause held", int'(fault_cause), 1);
    sample(480, 200, 200);
    ticks(4);
    chk("R8 all clear", int'(fault_cause), 0);
    @(negedge clk); reg_trip_ms = 8'd2;
    sample(400, 100, 200);
    ticks(2);
    chk("R8 same-cycle rank", int'(fault_cause), 1);
    sample(480, 200, 200);
    ticks(4);
    chk("R8 rank cleared", int'(shutdown_req), 0);
    @(negedge clk); reg_trip_ms = 8'd10;
  endtask

  task automatic t_strobe;
    @(negedge clk);
    vin_code = 12'd400;
    ticks(5);
    chk("R9 no strobe no effect", int'(shutdown_req), 0);
    sample(480, 200, 200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_uv_recover();
    t_ov_and_limits();
    t_regulation();
    t_mask();
    t_priority();
    t_strobe();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule